// File: doc/BRIEF.md
# Indexed Vector Timing Generator

This block derives a vector clock from the system clock and, within every vector, emits single-cycle edge pulses that a pattern engine uses to time its pin drivers and receivers. The vector length is a programmable count of system cycles from 1 to 256. A table of 64 timing groups holds the edge offsets. Each group has eight phase lanes, each with an assert and a return offset, and four window lanes, each with an open and a close offset. Every offset is a count of system cycles from the restart point of its lane.

A sequencer hands over one step per vector through a valid/ready pair. The step carries a group index. `step_ready` is high only in the last system cycle of each vector, so a step is taken exactly at a vector boundary. The producer holds `step_valid` and `step_index` steady until the transfer happens. If no step is offered at a boundary, the following vector runs idle. The group selected by a step is copied aside at the boundary, so table writes never disturb a vector that is already running. The phase lanes restart either once per vector or on every system cycle, as selected by a plain control pin. The window lanes always restart once per vector. The assignment of lanes to channels lies outside this block and does not change when the index changes.

Top module: `idx_timing_gen`

## Requirements
- R1: `vec_strobe` is high in the first system cycle of every vector. Each vector lasts P cycles, where P is the stored vector-length value (1 to 255) and a stored 0 means 256.
- R2: A write with `wr_addr[11]`=1 stores `wr_data` as the vector-length value. The vector already running keeps its old length, and the new length applies from the next vector boundary.
- R3: `step_ready` is high exactly in the last cycle of each vector. A step is accepted when `step_valid` and `step_ready` are both high, and its index governs the whole of the next vector.
- R4: A vector that follows a boundary with no accepted step produces no phase or window pulses.
- R5: A write with `wr_addr[11]`=0 targets group `wr_addr[10:5]` and slot `wr_addr[4:0]`. Slots 0 to 7 hold the assert offset of phase lane k=slot, slots 8 to 15 the return offset of lane slot-8, slots 16 to 19 the open offset of window lane slot-16, and slots 20 to 23 the close offset of window lane slot-20. Writes to slots 24 to 31 are discarded.
- R6: In an active vector, a window open or close output pulses for one cycle in the cycle whose position in the vector (0 at `vec_strobe`) equals its offset.
- R7: With `trig_sys`=0, the phase assert and return outputs pulse at their offsets, counted from the start of the vector, in the same way as the window edges.
- R8: With `trig_sys`=1, phase timing restarts on every system cycle. A phase edge with offset 0 pulses in every cycle of an active vector, and an edge with a non-zero offset never pulses.
- R9: An edge whose offset is equal to or greater than its restart period never pulses.
- R10: A table write to the group that the running vector uses does not change that vector's edges. It is seen by the next accepted step that selects the group.
- R11: After reset the stored vector length is 1, so `vec_strobe` and `step_ready` are high in every cycle, and every phase and window output is low until a step is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for table and vector length |
| wr_addr | input | 12 | Write address: bit 11 selects vector length, else group and slot |
| wr_data | input | 8 | Write data (offset or vector length) |
| trig_sys | input | 1 | Phase restart source: 0 per vector, 1 per system cycle |
| step_valid | input | 1 | Step offered by the sequencer |
| step_index | input | 6 | Timing group index of the offered step |
| step_ready | output | 1 | High in the last cycle of each vector |
| vec_strobe | output | 1 | High in the first cycle of each vector |
| ph_assert | output | 8 | Phase assert edge pulses, one bit per lane |
| ph_return | output | 8 | Phase return edge pulses, one bit per lane |
| win_open | output | 4 | Window open edge pulses, one bit per lane |
| win_close | output | 4 | Window close edge pulses, one bit per lane |

## Verification
The assertions assume that `step_valid` is low during reset and that the sequencer changes the step only through the handshake. The check on vectors without a step relies on this, because it looks at the transfer in the cycle before each vector start. They also assume that every group selected by a step has been written in each slot that is observed. The bench drives all inputs on the falling edge and keeps `step_valid` low except for the single cycle in which `step_ready` is already seen high. It writes the observed lanes of a group before it selects that group.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic {
    TRIG_VECTOR = 1'b0,
    TRIG_SYSTEM = 1'b1
  } phase_trig_e;

endpackage

// File: rtl/vtg_vclock.sv
module vtg_vclock #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [OFS_W-1:0] len_data,
  output logic [OFS_W-1:0] vcnt,
  output logic             vstart,
  output logic             vlast
);

  logic [OFS_W-1:0] len_pend;
  logic [OFS_W-1:0] len_act;
  logic [OFS_W-1:0] len_m1;

  // a stored 0 wraps to all ones, giving a period of 2**OFS_W
  assign len_m1 = len_act - OFS_W'(1);
  assign vlast  = (vcnt == len_m1);
  assign vstart = (vcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_pend <= OFS_W'(1);
      len_act  <= OFS_W'(1);
      vcnt     <= '0;
    end else begin
      if (len_wr) len_pend <= len_data;
      if (vlast) begin
        vcnt    <= '0;
        len_act <= len_pend;
      end else begin
        vcnt <= vcnt + OFS_W'(1);
      end
    end
  end

  // R3: the cycle after the last one is always a vector start
  p_last_then_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vlast |=> vstart);

  // R1: a vector longer than one cycle has a single start strobe
  p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vstart && !vlast) |=> !vstart);

endmodule

// File: rtl/vtg_set_table.sv
module vtg_set_table #(
  parameter int N_GROUP = 64,
  parameter int SLOT_N  = 24,
  parameter int OFS_W   = 8,
  parameter int GRP_W   = 6,
  parameter int SLOT_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tw_en,
  input  logic [GRP_W-1:0]              tw_grp,
  input  logic [SLOT_W-1:0]             tw_slot,
  input  logic [OFS_W-1:0]              tw_data,
  input  logic [GRP_W-1:0]              rd_grp,
  output logic [SLOT_N-1:0][OFS_W-1:0]  rd_row
);

  logic [SLOT_N-1:0][OFS_W-1:0] mem [N_GROUP];
  logic slot_ok;

  assign slot_ok = ({1'b0, tw_slot} < (SLOT_W+1)'(SLOT_N));
  assign rd_row  = mem[rd_grp];

  always_ff @(posedge clk) begin
    if (tw_en && slot_ok) mem[tw_grp][tw_slot] <= tw_data;
  end

  // R5: an accepted table write is found in its group and slot afterwards
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && slot_ok) |=> (mem[$past(tw_grp)][$past(tw_slot)] == $past(tw_data)));

endmodule

// File: rtl/vtg_edge_gen.sv
module vtg_edge_gen #(
  parameter int N_PHASE = 8,
  parameter int N_WIN   = 4,
  parameter int OFS_W   = 8,
  parameter int SLOT_N  = 2*N_PHASE + 2*N_WIN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          boundary,
  input  logic                          take,
  input  logic [SLOT_N-1:0][OFS_W-1:0]  row_in,
  input  vtg_pkg::phase_trig_e          trig,
  input  logic [OFS_W-1:0]              vcnt,
  output logic [N_PHASE-1:0]            pa,
  output logic [N_PHASE-1:0]            pr,
  output logic [N_WIN-1:0]              wo,
  output logic [N_WIN-1:0]              wc
);

  localparam int RET_BASE   = N_PHASE;
  localparam int OPEN_BASE  = 2*N_PHASE;
  localparam int CLOSE_BASE = 2*N_PHASE + N_WIN;

  logic [SLOT_N-1:0][OFS_W-1:0] shadow;
  logic                         busy;
  logic [OFS_W-1:0]             ph_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shadow <= '0;
    end else begin
      if (boundary) busy <= take;
      if (take) shadow <= row_in;
    end
  end

  // per-system-cycle restart keeps the phase position pinned at zero
  assign ph_cnt = (trig == vtg_pkg::TRIG_SYSTEM) ? '0 : vcnt;

  for (genvar k = 0; k < N_PHASE; k++) begin : g_phase
    assign pa[k] = busy && (ph_cnt == shadow[k]);
    assign pr[k] = busy && (ph_cnt == shadow[RET_BASE+k]);
  end

  for (genvar w = 0; w < N_WIN; w++) begin : g_window
    assign wo[w] = busy && (vcnt == shadow[OPEN_BASE+w]);
    assign wc[w] = busy && (vcnt == shadow[CLOSE_BASE+w]);
  end

  // R10: timing in use changes only when a new step is taken
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(shadow));

endmodule

// File: rtl/idx_timing_gen.sv
module idx_timing_gen #(
  parameter int N_PHASE = 8,
  parameter int N_WIN   = 4,
  parameter int N_GROUP = 64,
  parameter int OFS_W   = 8,
  localparam int GRP_W  = $clog2(N_GROUP),
  localparam int SLOT_N = 2*N_PHASE + 2*N_WIN,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int ADDR_W = 1 + GRP_W + SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [OFS_W-1:0]   wr_data,
  input  logic               trig_sys,
  input  logic               step_valid,
  input  logic [GRP_W-1:0]   step_index,
  output logic               step_ready,
  output logic               vec_strobe,
  output logic [N_PHASE-1:0] ph_assert,
  output logic [N_PHASE-1:0] ph_return,
  output logic [N_WIN-1:0]   win_open,
  output logic [N_WIN-1:0]   win_close
);

  logic                         sel_len;
  logic [OFS_W-1:0]             vcnt;
  logic                         vlast;
  logic                         step_take;
  logic [SLOT_N-1:0][OFS_W-1:0] grp_row;
  vtg_pkg::phase_trig_e         trig;

  assign sel_len    = wr_addr[ADDR_W-1];
  assign step_ready = vlast;
  assign step_take  = step_valid && vlast;
  assign trig       = vtg_pkg::phase_trig_e'(trig_sys);

  vtg_vclock #(.OFS_W(OFS_W)) u_vclock (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_wr   (wr_en && sel_len),
    .len_data (wr_data),
    .vcnt     (vcnt),
    .vstart   (vec_strobe),
    .vlast    (vlast)
  );

  vtg_set_table #(
    .N_GROUP (N_GROUP),
    .SLOT_N  (SLOT_N),
    .OFS_W   (OFS_W),
    .GRP_W   (GRP_W),
    .SLOT_W  (SLOT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .tw_en   (wr_en && !sel_len),
    .tw_grp  (wr_addr[SLOT_W +: GRP_W]),
    .tw_slot (wr_addr[SLOT_W-1:0]),
    .tw_data (wr_data),
    .rd_grp  (step_index),
    .rd_row  (grp_row)
  );

  vtg_edge_gen #(
    .N_PHASE (N_PHASE),
    .N_WIN   (N_WIN),
    .OFS_W   (OFS_W),
    .SLOT_N  (SLOT_N)
  ) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (vlast),
    .take     (step_take),
    .row_in   (grp_row),
    .trig     (trig),
    .vcnt     (vcnt),
    .pa       (ph_assert),
    .pr       (ph_return),
    .wo       (win_open),
    .wc       (win_close)
  );

  // R4: a vector entered without a step stays silent in its first cycle
  p_idle_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_strobe && !$past(step_take)) |->
      (ph_assert == '0 && ph_return == '0 && win_open == '0 && win_close == '0));

endmodule

// File: tb/test_idx_timing_gen.sv
module test_idx_timing_gen;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int cpv; int trig; int grp; int pl; int a; int r; int wl; int o; int c;
    int pa_n; int pa_p; int pr_n; int pr_p; int wo_n; int wo_p; int wc_n; int wc_p;
  } case_t;

  // lane offsets and expected pulse count / first position in the vector
  localparam case_t CASES [7] = '{
    '{4, 0,  5, 0,   2,   3, 0,   1,   3, 1,   2, 1,   3, 1,   1, 1,   3},
    '{1, 0, 63, 3,   0,   0, 1,   0,   0, 1,   0, 1,   0, 1,   0, 1,   0},
    '{5, 0,  0, 7,   5,   1, 3,   4,   9, 0,  -1, 1,   1, 1,   4, 0,  -1},
    '{6, 1, 17, 2,   0,   1, 2,   2,   1, 6,   0, 0,  -1, 1,   2, 1,   1},
    '{6, 1, 40, 5,   2,   0, 0,   5,   0, 0,  -1, 6,   0, 1,   5, 1,   0},
    '{0, 0, 33, 1, 255, 128, 1, 200,   0, 1, 255, 1, 128, 1, 200, 1,   0},
    '{3, 0,  8, 4,   9,   2, 2,   2, 200, 0,  -1, 1,   2, 1,   2, 0,  -1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic        trig_sys;
  logic        step_valid;
  logic [5:0]  step_index;
  logic        step_ready;
  logic        vec_strobe;
  logic [7:0]  ph_assert;
  logic [7:0]  ph_return;
  logic [3:0]  win_open;
  logic [3:0]  win_close;

  int n_chk = 0;
  int n_bad = 0;
  int r_pa_n, r_pa_p, r_pr_n, r_pr_p, r_wo_n, r_wo_p, r_wc_n, r_wc_p;
  int r_st_n, r_rdy_n, r_rdy_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_timing_gen i_idx_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_sys(trig_sys), .step_valid(step_valid), .step_index(step_index),
    .step_ready(step_ready), .vec_strobe(vec_strobe), .ph_assert(ph_assert),
    .ph_return(ph_return), .win_open(win_open), .win_close(win_close)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] tab_addr(input int g, input int s);
    return {1'b0, 6'(g), 5'(s)};
  endfunction

  task automatic wr(input logic [11:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    while (!step_ready) @(negedge clk);
  endtask

  // waits for a boundary, optionally hands over a step, then observes one vector
  task automatic run_vec(input bit send, input int grp, input int p, input int pl, input int wl);
    wait_ready();
    step_valid = send; step_index = 6'(grp);
    @(negedge clk);
    step_valid = 1'b0;
    r_pa_n = 0; r_pr_n = 0; r_wo_n = 0; r_wc_n = 0; r_st_n = 0; r_rdy_n = 0;
    r_pa_p = -1; r_pr_p = -1; r_wo_p = -1; r_wc_p = -1;
    for (int i = 0; i < p; i++) begin
      if (ph_assert[pl]) begin if (r_pa_n == 0) r_pa_p = i; r_pa_n++; end
      if (ph_return[pl]) begin if (r_pr_n == 0) r_pr_p = i; r_pr_n++; end
      if (win_open[wl])  begin if (r_wo_n == 0) r_wo_p = i; r_wo_n++; end
      if (win_close[wl]) begin if (r_wc_n == 0) r_wc_p = i; r_wc_n++; end
      if (vec_strobe) r_st_n++;
      if (step_ready) r_rdy_n++;
      r_rdy_end = int'(step_ready);
      if (i < p-1) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    trig_sys = 1'b0; step_valid = 1'b0; step_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state, vector length one, no edges
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11", "vec_strobe", int'(vec_strobe), 1);
      check("R11", "step_ready", int'(step_ready), 1);
      check("R11", "edges", int'({ph_assert, ph_return, win_open, win_close}), 0);
    end

    // table of cases: R1 R2 R3 R5 R6 R7 R8 R9
    foreach (CASES[n]) begin
      automatic case_t cs = CASES[n];
      automatic int p = (cs.cpv == 0) ? 256 : cs.cpv;
      wr(tab_addr(cs.grp, cs.pl), cs.a);
      wr(tab_addr(cs.grp, 8 + cs.pl), cs.r);
      wr(tab_addr(cs.grp, 16 + cs.wl), cs.o);
      wr(tab_addr(cs.grp, 20 + cs.wl), cs.c);
      wr(12'h800, cs.cpv);
      trig_sys = cs.trig[0];
      run_vec(1'b1, cs.grp, p, cs.pl, cs.wl);
      check("R1", "strobe count", r_st_n, 1);
      check("R3", "ready count", r_rdy_n, 1);
      check("R3", "ready in last cycle", r_rdy_end, 1);
      check(cs.pa_n == 0 ? "R9" : (cs.trig != 0 ? "R8" : "R7"), "assert count", r_pa_n, cs.pa_n);
      check(cs.pa_n == 0 ? "R9" : (cs.trig != 0 ? "R8" : "R7"), "assert pos", r_pa_p, cs.pa_p);
      check(cs.pr_n == 0 ? "R9" : (cs.trig != 0 ? "R8" : "R7"), "return count", r_pr_n, cs.pr_n);
      check(cs.pr_n == 0 ? "R9" : (cs.trig != 0 ? "R8" : "R7"), "return pos", r_pr_p, cs.pr_p);
      check(cs.wo_n == 0 ? "R9" : "R6", "open count", r_wo_n, cs.wo_n);
      check(cs.wo_n == 0 ? "R9" : "R6", "open pos", r_wo_p, cs.wo_p);
      check(cs.wc_n == 0 ? "R9" : "R6", "close count", r_wc_n, cs.wc_n);
      check(cs.wc_n == 0 ? "R9" : "R6", "close pos", r_wc_p, cs.wc_p);
    end

    // R4: no step offered, group 5 still holds lane 0 edges
    trig_sys = 1'b0;
    wr(12'h800, 4);
    run_vec(1'b1, 5, 4, 0, 0);
    run_vec(1'b0, 5, 4, 0, 0);
    check("R4", "idle edges", r_pa_n + r_pr_n + r_wo_n + r_wc_n, 0);
    check("R4", "idle strobe", r_st_n, 1);

    // R2: length write during a running vector keeps its old length
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'h800; wr_data = 8'd3;
    @(negedge clk);
    wr_en = 1'b0;
    begin
      automatic int k = 0;
      while (!step_ready) begin @(negedge clk); k++; end
      check("R2", "cycles to end of old vector", k, 2);
      @(negedge clk);
      k = 0;
      while (!step_ready) begin @(negedge clk); k++; end
      check("R2", "cycles to end of new vector", k, 2);
    end

    // R10: write to the group in use lands only for the next vector
    wr(tab_addr(12, 0), 6);
    wr(12'h800, 8);
    wait_ready();
    run_vec(1'b0, 12, 1, 0, 0);
    wait_ready();
    step_valid = 1'b1; step_index = 6'd12;
    @(negedge clk);
    step_valid = 1'b0;
    r_pa_n = 0; r_pa_p = -1;
    for (int i = 0; i < 8; i++) begin
      if (ph_assert[0]) begin if (r_pa_n == 0) r_pa_p = i; r_pa_n++; end
      if (i == 0) begin wr_en = 1'b1; wr_addr = tab_addr(12, 0); wr_data = 8'd3; end
      else wr_en = 1'b0;
      if (i < 7) @(negedge clk);
    end
    check("R10", "running vector assert pos", r_pa_p, 6);
    check("R10", "running vector assert count", r_pa_n, 1);
    run_vec(1'b1, 12, 8, 0, 0);
    check("R10", "next vector assert pos", r_pa_p, 3);

    // R5: slot 24 lies outside the map and must not reach slot 0
    wr(tab_addr(12, 24), 1);
    run_vec(1'b1, 12, 8, 0, 0);
    check("R5", "assert pos after discarded write", r_pa_p, 3);
    check("R5", "assert count after discarded write", r_pa_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule